// File: doc/BRIEF.md
# Nibble-Decoded Sequential CPU Core

A small processor core that runs programs held in its own byte-wide program memory. Each instruction is a 16-bit word assembled from two consecutive bytes, most significant byte first. The word is split into four 4-bit fields: a major opcode, a destination register index X, a source register index Y, and a minor opcode. The core dispatches on the major and minor fields together. It implements two operations: a register-to-register 8-bit add and a halt. Every other word stops the core and raises a fault flag, and the offending word is kept for inspection.

Programs are run in three steps. First, while the core is idle, the loader port writes program bytes and presets any of the sixteen 8-bit registers. Then a one-cycle start pulse launches execution from address 0. The core then runs until it halts or faults and returns to idle. A combinational debug port reads any register at any time, which lets results be collected after a run or observed during one.

Top module: `nib_core`

## Requirements
- R1: After reset the core is idle (busy_o=0, halted_o=0, fault_o=0, fault_word_o=0) and every register reads 0 on the debug port.
- R2: While idle, ld_mem_we_i writes ld_data_i to program byte ld_addr_i and ld_reg_we_i writes ld_reg_data_i to register ld_reg_idx_i. dbg_data_o shows register dbg_idx_i combinationally.
- R3: A start pulse while idle sets busy_o in the next cycle, clears halted_o, fault_o and fault_word_o, and begins fetching at address 0.
- R4: The instruction word is {mem[pc], mem[pc+1]}. Bits 15:12 are the major opcode, 11:8 the X index, 7:4 the Y index and 3:0 the minor opcode. Dispatch needs both opcode nibbles to match, so for example 0x0004 and 0x8015 are not valid.
- R5: A word 0x8XY4 writes (RX + RY) mod 256 into RX. This includes X equal to Y, which doubles the register. No other register changes.
- R6: The word 0x0000 ends the run: busy_o falls and halted_o rises.
- R7: Any other word ends the run with fault_o=1 and fault_word_o equal to that word, halted_o=0, and no register change.
- R8: Each instruction takes exactly 3 cycles from fetch to completion. The program counter advances by 2 per instruction and wraps from 0xFFE to 0x000.
- R9: While busy, loader writes and start pulses have no effect.
- R10: After a halt or fault the core stays idle and keeps halted_o/fault_o/fault_word_o until the next start. A new start reruns from address 0 with the register contents retained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| ld_mem_we_i | input | 1 | Program byte write enable |
| ld_addr_i | input | 12 | Program byte address |
| ld_data_i | input | 8 | Program byte data |
| ld_reg_we_i | input | 1 | Register preset enable |
| ld_reg_idx_i | input | 4 | Register preset index |
| ld_reg_data_i | input | 8 | Register preset value |
| dbg_idx_i | input | 4 | Debug read register index |
| dbg_data_o | output | 8 | Debug read data |
| busy_o | output | 1 | Program running |
| halted_o | output | 1 | Last run ended on halt |
| fault_o | output | 1 | Last run ended on an unknown word |
| fault_word_o | output | 16 | Word that caused the fault |

## Verification
The hardest behaviour to reach is the program counter wrapping from the top of memory back to address 0. Only a program that fills all 4096 bytes without halting can get there. The bench fills memory with harmless adds, places a marker add at address 0, and reads the marker register through the debug port after 2049 instruction times. During that same long run it attempts a register preset, a memory write into the upcoming path and a restart. It then checks at the ports that none of them took effect. Random add programs ending in a halt or in random invalid words are compared with a bench-side model.

// File: rtl/nib_pkg.sv
package nib_pkg;
  localparam int unsigned NIB_W = 4;
  localparam int unsigned IW    = 4 * NIB_W;
  localparam int unsigned NREG  = 1 << NIB_W;

  localparam logic [NIB_W-1:0] MAJ_SYS  = 4'h0;
  localparam logic [NIB_W-1:0] MIN_HALT = 4'h0;
  localparam logic [NIB_W-1:0] MAJ_ALU  = 4'h8;
  localparam logic [NIB_W-1:0] MIN_ADD  = 4'h4;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH_HI, ST_FETCH_LO, ST_EXEC} nib_state_e;
  typedef enum logic [1:0] {OP_HALT, OP_ADD, OP_BAD} nib_op_e;

  typedef struct packed {
    logic [NIB_W-1:0] major;
    logic [NIB_W-1:0] rx;
    logic [NIB_W-1:0] ry;
    logic [NIB_W-1:0] minor;
  } nib_word_t;

  function automatic nib_op_e nib_decode(nib_word_t w);
    if (w.major == MAJ_SYS && w.minor == MIN_HALT && w.rx == '0 && w.ry == '0) return OP_HALT;
    if (w.major == MAJ_ALU && w.minor == MIN_ADD) return OP_ADD;
    return OP_BAD;
  endfunction
endpackage

// File: rtl/nib_prog_mem.sv
module nib_prog_mem #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/nib_regfile.sv
module nib_regfile #(
  parameter int unsigned REG_W = 8,
  parameter int unsigned NREG  = 16,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [IDX_W-1:0] ra_idx_i,
  output logic [REG_W-1:0] ra_data_o,
  input  logic [IDX_W-1:0] rb_idx_i,
  output logic [REG_W-1:0] rb_data_o,
  input  logic [IDX_W-1:0] rc_idx_i,
  output logic [REG_W-1:0] rc_data_o
);
  logic [REG_W-1:0] regs_w [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [REG_W-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              r_q <= '0;
      else if (we_i && widx_i == IDX_W'(g))     r_q <= wdata_i;
    end
    assign regs_w[g] = r_q;
  end

  assign ra_data_o = regs_w[ra_idx_i];
  assign rb_data_o = regs_w[rb_idx_i];
  assign rc_data_o = regs_w[rc_idx_i];
endmodule

// File: rtl/nib_ctrl.sv
module nib_ctrl
  import nib_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned REG_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        mem_rdata_i,
  output logic [ADDR_W-1:0] mem_raddr_o,
  output logic [NIB_W-1:0]  rx_idx_o,
  output logic [NIB_W-1:0]  ry_idx_o,
  input  logic [REG_W-1:0]  rx_data_i,
  input  logic [REG_W-1:0]  ry_data_i,
  output logic              wr_en_o,
  output logic [NIB_W-1:0]  wr_idx_o,
  output logic [REG_W-1:0]  wr_data_o,
  output logic              busy_o,
  output logic              halted_o,
  output logic              fault_o,
  output logic [IW-1:0]     fault_word_o
);
  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(2);

  nib_state_e        state_q;
  logic [ADDR_W-1:0] pc_q;
  logic [7:0]        hi_q;
  logic              halted_q, fault_q;
  logic [IW-1:0]     fault_word_q;
  nib_word_t         word;
  nib_op_e           op;

  assign word        = nib_word_t'({hi_q, mem_rdata_i});
  assign op          = nib_decode(word);
  assign mem_raddr_o = (state_q == ST_FETCH_LO) ? pc_q + ADDR_W'(1) : pc_q;
  assign rx_idx_o    = word.rx;
  assign ry_idx_o    = word.ry;
  assign wr_en_o     = (state_q == ST_EXEC) && (op == OP_ADD);
  assign wr_idx_o    = word.rx;
  assign wr_data_o   = rx_data_i + ry_data_i;  // wraps mod 2^REG_W

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      pc_q         <= '0;
      hi_q         <= '0;
      halted_q     <= 1'b0;
      fault_q      <= 1'b0;
      fault_word_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          pc_q         <= '0;
          halted_q     <= 1'b0;
          fault_q      <= 1'b0;
          fault_word_q <= '0;
          state_q      <= ST_FETCH_HI;
        end
        ST_FETCH_HI: state_q <= ST_FETCH_LO;
        ST_FETCH_LO: begin
          hi_q    <= mem_rdata_i;
          state_q <= ST_EXEC;
        end
        ST_EXEC: begin
          pc_q <= pc_q + PC_STEP;
          unique case (op)
            OP_HALT: begin
              halted_q <= 1'b1;
              state_q  <= ST_IDLE;
            end
            OP_ADD: state_q <= ST_FETCH_HI;
            default: begin
              fault_q      <= 1'b1;
              fault_word_q <= word;
              state_q      <= ST_IDLE;
            end
          endcase
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = state_q != ST_IDLE;
  assign halted_o     = halted_q;
  assign fault_o      = fault_q;
  assign fault_word_o = fault_word_q;
endmodule

// File: rtl/nib_core.sv
module nib_core
  import nib_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned REG_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ld_mem_we_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [7:0]        ld_data_i,
  input  logic              ld_reg_we_i,
  input  logic [NIB_W-1:0]  ld_reg_idx_i,
  input  logic [REG_W-1:0]  ld_reg_data_i,
  input  logic [NIB_W-1:0]  dbg_idx_i,
  output logic [REG_W-1:0]  dbg_data_o,
  output logic              busy_o,
  output logic              halted_o,
  output logic              fault_o,
  output logic [IW-1:0]     fault_word_o
);
  logic [ADDR_W-1:0] mem_raddr;
  logic [7:0]        mem_rdata;
  logic [NIB_W-1:0]  rx_idx, ry_idx, ex_idx, rf_widx;
  logic [REG_W-1:0]  rx_data, ry_data, ex_data, rf_wdata;
  logic              ex_we, rf_we, busy;

  nib_prog_mem #(.ADDR_W(ADDR_W), .DATA_W(8)) u_mem (
    .clk_i   (clk_i),
    .we_i    (ld_mem_we_i && !busy),
    .waddr_i (ld_addr_i),
    .wdata_i (ld_data_i),
    .raddr_i (mem_raddr),
    .rdata_o (mem_rdata)
  );

  // loader only owns the write port while idle
  assign rf_we    = ex_we || (ld_reg_we_i && !busy);
  assign rf_widx  = ex_we ? ex_idx  : ld_reg_idx_i;
  assign rf_wdata = ex_we ? ex_data : ld_reg_data_i;

  nib_regfile #(.REG_W(REG_W), .NREG(NREG)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (rf_we),
    .widx_i    (rf_widx),
    .wdata_i   (rf_wdata),
    .ra_idx_i  (rx_idx),
    .ra_data_o (rx_data),
    .rb_idx_i  (ry_idx),
    .rb_data_o (ry_data),
    .rc_idx_i  (dbg_idx_i),
    .rc_data_o (dbg_data_o)
  );

  nib_ctrl #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .mem_rdata_i  (mem_rdata),
    .mem_raddr_o  (mem_raddr),
    .rx_idx_o     (rx_idx),
    .ry_idx_o     (ry_idx),
    .rx_data_i    (rx_data),
    .ry_data_i    (ry_data),
    .wr_en_o      (ex_we),
    .wr_idx_o     (ex_idx),
    .wr_data_o    (ex_data),
    .busy_o       (busy),
    .halted_o     (halted_o),
    .fault_o      (fault_o),
    .fault_word_o (fault_word_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/nib_core_chk.sv
module nib_core_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        busy_i,
  input logic        halted_i,
  input logic        fault_i,
  input logic [15:0] fault_word_i
);
  AST_START_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && start_i) |=> (busy_i && !halted_i && !fault_i && fault_word_i == 16'h0)); // R3

  AST_HALT_ENDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halted_i) |-> (!busy_i && $past(busy_i))); // R6

  AST_FAULT_WORD_BAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |-> (fault_word_i != 16'h0 && !(fault_word_i[15:12] == 4'h8 && fault_word_i[3:0] == 4'h4))); // R7

  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(halted_i && fault_i)); // R7

  AST_RUN_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (!halted_i && !fault_i)); // R10

  AST_OUTCOME_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !start_i) |=> (!busy_i && $stable(halted_i) && $stable(fault_i) && $stable(fault_word_i))); // R10
endmodule

bind nib_core nib_core_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .busy_i       (busy_o),
  .halted_i     (halted_o),
  .fault_i      (fault_o),
  .fault_word_i (fault_word_o)
);

// File: tb/sim_nib_core.sv
module sim_nib_core;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        ld_mem_we_i = 1'b0;
  logic [11:0] ld_addr_i = '0;
  logic [7:0]  ld_data_i = '0;
  logic        ld_reg_we_i = 1'b0;
  logic [3:0]  ld_reg_idx_i = '0;
  logic [7:0]  ld_reg_data_i = '0;
  logic [3:0]  dbg_idx_i = '0;
  logic [7:0]  dbg_data_o;
  logic        busy_o, halted_o, fault_o;
  logic [15:0] fault_word_o;

  int total = 0;
  int bad = 0;

  logic [7:0] bm [4096];
  logic [7:0] mreg [16];

  always #2 clk = ~clk;

  nib_core u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .ld_mem_we_i(ld_mem_we_i), .ld_addr_i(ld_addr_i), .ld_data_i(ld_data_i),
    .ld_reg_we_i(ld_reg_we_i), .ld_reg_idx_i(ld_reg_idx_i), .ld_reg_data_i(ld_reg_data_i),
    .dbg_idx_i(dbg_idx_i), .dbg_data_o(dbg_data_o),
    .busy_o(busy_o), .halted_o(halted_o), .fault_o(fault_o), .fault_word_o(fault_word_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 16; i++) mreg[i] = '0;
  endtask

  task automatic wr_mem(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    ld_mem_we_i = 1'b1; ld_addr_i = a; ld_data_i = d;
    @(negedge clk);
    ld_mem_we_i = 1'b0;
    bm[a] = d;
  endtask

  task automatic wr_word(input logic [11:0] a, input logic [15:0] w);
    wr_mem(a, w[15:8]);
    wr_mem(a + 12'd1, w[7:0]);
  endtask

  task automatic wr_reg(input logic [3:0] i, input logic [7:0] d);
    @(negedge clk);
    ld_reg_we_i = 1'b1; ld_reg_idx_i = i; ld_reg_data_i = d;
    @(negedge clk);
    ld_reg_we_i = 1'b0;
    mreg[i] = d;
  endtask

  task automatic rd_reg(input logic [3:0] i, output logic [7:0] d);
    dbg_idx_i = i;
    #1;
    d = dbg_data_o;
  endtask

  // returns at the negedge after the accepting edge
  task automatic pulse_start();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy_o; i++) @(negedge clk);
  endtask

  task automatic model_run(output logic h, output logic f, output logic [15:0] fw);
    logic [11:0] pc;
    logic [15:0] w;
    pc = '0; h = 1'b0; f = 1'b0; fw = '0;
    for (int s = 0; s < 64; s++) begin
      w = {bm[pc], bm[pc + 12'd1]};
      pc = pc + 12'd2;
      if (w == 16'h0) begin h = 1'b1; return; end
      else if (w[15:12] == 4'h8 && w[3:0] == 4'h4) mreg[w[11:8]] = mreg[w[11:8]] + mreg[w[7:4]];
      else begin f = 1'b1; fw = w; return; end
    end
  endtask

  function automatic logic [15:0] rand_bad();
    logic [15:0] w;
    w = 16'($urandom);
    while (w == 16'h0 || (w[15:12] == 4'h8 && w[3:0] == 4'h4)) w = 16'($urandom);
    return w;
  endfunction

  task automatic check_regs(input string req);
    logic [7:0] v;
    for (int i = 0; i < 16; i++) begin
      rd_reg(4'(i), v);
      check(req, {24'h0, v}, {24'h0, mreg[i]});
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0]  v;
    logic        eh, ef;
    logic [15:0] ew;
    void'($urandom(32'd4242));

    do_reset();
    // R1 reset state
    check("R1 busy", busy_o, 0);
    check("R1 halted", halted_o, 0);
    check("R1 fault", fault_o, 0);
    check("R1 fault_word", fault_word_o, 0);
    check_regs("R1 regs");

    // R2 directed program, R5 sums, R8 timing
    wr_reg(4'd0, 8'd5); wr_reg(4'd1, 8'd10); wr_reg(4'd2, 8'd10); wr_reg(4'd3, 8'd10);
    rd_reg(4'd3, v); check("R2 preset", v, 10);
    wr_word(12'h000, 16'h8014); wr_word(12'h002, 16'h8024);
    wr_word(12'h004, 16'h8034); wr_word(12'h006, 16'h0000);
    pulse_start();
    check("R3 busy after start", busy_o, 1);
    repeat (11) @(negedge clk);
    check("R8 not yet halted", halted_o, 0);
    @(negedge clk);
    check("R8 halted at cycle 12", halted_o, 1);
    check("R6 busy low", busy_o, 0);
    check("R6 no fault", fault_o, 0);
    rd_reg(4'd0, v); check("R5 R0 sum", v, 35);
    rd_reg(4'd1, v); check("R5 R1 kept", v, 10);

    // R10 rerun keeps registers
    pulse_start();
    wait_idle();
    rd_reg(4'd0, v); check("R10 rerun R0", v, 65);
    check("R10 halted again", halted_o, 1);
    repeat (5) @(negedge clk);
    check("R10 stays idle", busy_o, 0);
    check("R10 halted held", halted_o, 1);
    mreg[0] = 8'd65;

    // R5 X==Y doubling with wrap
    wr_reg(4'd1, 8'd200);
    wr_word(12'h000, 16'h8114); wr_word(12'h002, 16'h0000);
    pulse_start(); wait_idle();
    rd_reg(4'd1, v); check("R5 doubling wraps", v, 8'd144);
    mreg[1] = 8'd144;

    // R7 / R4 decode needs both nibbles
    wr_word(12'h000, 16'h8015);
    pulse_start(); wait_idle();
    check("R7 fault", fault_o, 1);
    check("R7 halted low", halted_o, 0);
    check("R7 word", fault_word_o, 16'h8015);
    check_regs("R7 regs unchanged");
    wr_word(12'h000, 16'h0004);
    pulse_start(); wait_idle();
    check("R4 0x0004 faults", fault_o, 1);
    check("R4 word", fault_word_o, 16'h0004);
    wr_word(12'h000, 16'h0000);
    pulse_start();
    check("R3 clears fault", fault_o, 0);
    wait_idle();
    check("R6 halt after fault", halted_o, 1);

    // random programs vs model: R4 R5 R6 R7
    for (int t = 0; t < 40; t++) begin
      int n;
      logic [15:0] term;
      for (int i = 0; i < 16; i++) wr_reg(4'(i), 8'($urandom));
      n = 1 + int'($urandom % 10);
      for (int k = 0; k < n; k++)
        wr_word(12'(2 * k), {4'h8, 4'($urandom), 4'($urandom), 4'h4});
      term = ($urandom % 2 == 0) ? 16'h0000 : rand_bad();
      wr_word(12'(2 * n), term);
      model_run(eh, ef, ew);
      pulse_start(); wait_idle();
      check("R6 random halted", halted_o, eh);
      check("R7 random fault", fault_o, ef);
      check("R7 random word", fault_word_o, ew);
      check_regs("R5 random regs");
    end

    // R8 wrap and R9 busy-ignore
    do_reset();
    wr_reg(4'd2, 8'd1);
    wr_word(12'h000, 16'h8124);
    for (int a = 2; a < 4096; a += 2) wr_word(12'(a), 16'h8554);
    pulse_start();
    repeat (3000) @(negedge clk);
    rd_reg(4'd1, v); check("R8 first pass marker", v, 1);
    start_i = 1'b1; ld_reg_we_i = 1'b1; ld_reg_idx_i = 4'd1; ld_reg_data_i = 8'h77;
    ld_mem_we_i = 1'b1; ld_addr_i = 12'h002; ld_data_i = 8'h00;
    @(negedge clk);
    start_i = 1'b0; ld_reg_we_i = 1'b0; ld_mem_we_i = 1'b0;
    repeat (6) @(negedge clk);
    rd_reg(4'd1, v); check("R9 preset/start ignored", v, 1);
    check("R9 still busy", busy_o, 1);
    repeat (3153) @(negedge clk);
    rd_reg(4'd1, v); check("R8 pc wrapped to 0", v, 2);
    check("R9 mem write ignored", fault_o, 0);
    check("R8 still running", busy_o, 1);
    do_reset();

    summary();
    $finish;
  end
endmodule